// File: doc/BRIEF.md
# Exception Capture Registers

This block keeps the state that a multi-cycle processor records when an instruction faults. It has two registers. The first holds the address of the instruction that faulted. The second records why it faulted. The block also drives the fixed handler address that the program-counter input mux selects when control moves to the exception handler.

The control sequencer raises a separate write strobe for each register. It also sets a one-bit select that names the fault kind: an illegal or reserved opcode, or an integer overflow. The fetch stage has already advanced the program counter by one instruction (4 bytes) when a fault is detected. For that reason the address register stores the incoming counter minus 4, which is the faulting instruction's own address. Both registers keep their contents whenever their strobes are low. No privilege-mode change, handler return, interrupt or other fault kind is handled here.

Top module: `exc_state_unit`

## Requirements
- R1: While `rst_n` is low, both `epc_q` and `cause_q` read zero. This holds after power-up and after a reset applied in the middle of a run.
- R2: When `epc_we` is high at a rising clock edge, `epc_q` holds `pc_in - 4` after that edge.
- R3: When `epc_we` is low at a rising clock edge, `epc_q` keeps its previous value, whatever `cause_we`, `cause_sel` and `pc_in` do.
- R4: When `cause_we` is high and `cause_sel` is 0 (illegal opcode) at a rising edge, `cause_q` becomes 0x00000028. This is code 10 in bits 6:2.
- R5: When `cause_we` is high and `cause_sel` is 1 (integer overflow) at a rising edge, `cause_q` becomes 0x00000030. This is code 12 in bits 6:2.
- R6: When `cause_we` is low at a rising edge, `cause_q` keeps its previous value, whatever `epc_we`, `cause_sel` and `pc_in` do.
- R7: `vector_addr` always reads 0x80000180.
- R8: The subtraction in R2 wraps modulo 2^32, so a `pc_in` of 0 stores 0xFFFFFFFC.
- R9: Bits of `cause_q` outside 6:2 are always zero. Every cause write replaces the whole register, so no earlier code survives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| epc_we | input | 1 | Write strobe for the faulting-address register |
| cause_we | input | 1 | Write strobe for the cause register |
| cause_sel | input | 1 | Fault kind: 0 illegal opcode, 1 integer overflow |
| pc_in | input | 32 | Program counter, already advanced by 4 in fetch |
| epc_q | output | 32 | Stored faulting-instruction address |
| cause_q | output | 32 | Cause register, code in bits 6:2 |
| vector_addr | output | 32 | Handler address, the constant 0x80000180 |

## Verification
The stimulus raises each strobe alone, then both strobes together, then neither. This shows that each register answers only to its own strobe and that the select line affects nothing while `cause_we` is low. The cause writes alternate between the two fault kinds, including a switch from overflow back to illegal opcode, which would expose a write that merges bits instead of replacing them. Counter values include a typical text-segment address, a high boot address and zero, so a missing subtraction, a wrong offset and a failure to wrap all give distinct wrong values. A reset in the middle of the run, after both registers hold non-zero values, shows that clearing does not depend on power-up state.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int unsigned XLEN_DEF     = 32;
   localparam int unsigned PC_STEP_DEF  = 4;
   localparam int unsigned CODE_W_DEF   = 5;
   localparam int unsigned CODE_LSB_DEF = 2;
   localparam int unsigned CODE_ILLEGAL = 10;
   localparam int unsigned CODE_OVFLOW  = 12;
   localparam logic [31:0] HANDLER_ADDR = 32'h8000_0180;

   typedef enum logic {
      FAULT_ILLEGAL_OP = 1'b0,
      FAULT_OVERFLOW   = 1'b1
   } fault_kind_e;
endpackage

// File: rtl/exc_epc_reg.sv
module exc_epc_reg #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned STEP   = 4,
   parameter bit          ADJUST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [XLEN-1:0] pc_in,
   output logic [XLEN-1:0] epc_q
);
   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   logic [XLEN-1:0] capt;

   generate
      if (ADJUST) begin : g_rewind
         assign capt = pc_in - STEP_V;

         AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (epc_q + STEP_V) == $past(pc_in)); // R2
      end else begin : g_direct
         assign capt = pc_in;

         AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> epc_q == $past(pc_in)); // R2
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  epc_q <= '0;
      else if (we) epc_q <= capt;
   end

   AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(epc_q)); // R3
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
   import exc_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CODE_W   = 5,
   parameter int unsigned CODE_LSB = 2,
   parameter int unsigned CODE_A   = 10,
   parameter int unsigned CODE_B   = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  fault_kind_e     kind,
   output logic [XLEN-1:0] cause_q
);
   localparam logic [XLEN-1:0] WORD_A     = XLEN'(CODE_A) << CODE_LSB;
   localparam logic [XLEN-1:0] WORD_B     = XLEN'(CODE_B) << CODE_LSB;
   localparam logic [XLEN-1:0] FIELD_MASK = ((XLEN'(1) << CODE_W) - XLEN'(1)) << CODE_LSB;

   logic [CODE_W-1:0] code;
   logic [XLEN-1:0]   word;

   always_comb begin
      unique case (kind)
         FAULT_OVERFLOW: code = CODE_W'(CODE_B);
         default:        code = CODE_W'(CODE_A);
      endcase
      word = '0;
      word[CODE_LSB +: CODE_W] = code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cause_q <= '0;
      else if (we) cause_q <= word;
   end

   AST_CAUSE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (we && kind == FAULT_ILLEGAL_OP) |=> cause_q == WORD_A); // R4
   AST_CAUSE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (we && kind == FAULT_OVERFLOW) |=> cause_q == WORD_B); // R5
   AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cause_q)); // R6
   AST_CAUSE_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cause_q & ~FIELD_MASK) == 0); // R9
endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
   import exc_pkg::*;
#(
   parameter int unsigned XLEN      = XLEN_DEF,
   parameter int unsigned PC_STEP   = PC_STEP_DEF,
   parameter bit          PC_REWIND = 1'b1,
   parameter int unsigned CODE_W    = CODE_W_DEF,
   parameter int unsigned CODE_LSB  = CODE_LSB_DEF,
   parameter int unsigned CODE_ILL  = CODE_ILLEGAL,
   parameter int unsigned CODE_OVF  = CODE_OVFLOW,
   parameter logic [31:0] VECTOR    = HANDLER_ADDR
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            epc_we,
   input  logic            cause_we,
   input  logic            cause_sel,
   input  logic [XLEN-1:0] pc_in,
   output logic [XLEN-1:0] epc_q,
   output logic [XLEN-1:0] cause_q,
   output logic [XLEN-1:0] vector_addr
);
   localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;
   localparam int unsigned FIELD_HI = CODE_LSB + CODE_W;

   generate
      if (FIELD_HI > XLEN) begin : g_bad_field
         $error("cause field does not fit in the register width");
      end
      if (CODE_ILL > CODE_MAX || CODE_OVF > CODE_MAX) begin : g_bad_code
         $error("cause code exceeds field width");
      end
      if (CODE_ILL == CODE_OVF) begin : g_same_code
         $error("cause codes must differ");
      end
      if (XLEN < 32) begin : g_narrow
         $error("register width below vector width");
      end
   endgenerate

   fault_kind_e kind;
   assign kind        = fault_kind_e'(cause_sel);
   assign vector_addr = XLEN'(VECTOR);

   exc_epc_reg #(
      .XLEN   (XLEN),
      .STEP   (PC_STEP),
      .ADJUST (PC_REWIND)
   ) u_epc (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (epc_we),
      .pc_in (pc_in),
      .epc_q (epc_q)
   );

   exc_cause_reg #(
      .XLEN     (XLEN),
      .CODE_W   (CODE_W),
      .CODE_LSB (CODE_LSB),
      .CODE_A   (CODE_ILL),
      .CODE_B   (CODE_OVF)
   ) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cause_we),
      .kind    (kind),
      .cause_q (cause_q)
   );
endmodule

// File: tb/sim_exc_state_unit.sv
`timescale 1ns/1ps
module sim_exc_state_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        epc_we = 1'b0;
   logic        cause_we = 1'b0;
   logic        cause_sel = 1'b0;
   logic [31:0] pc_in = '0;
   logic [31:0] epc_q, cause_q, vector_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   exc_state_unit u0 (
      .clk(clk), .rst_n(rst_n), .epc_we(epc_we), .cause_we(cause_we),
      .cause_sel(cause_sel), .pc_in(pc_in), .epc_q(epc_q),
      .cause_q(cause_q), .vector_addr(vector_addr)
   );

   typedef struct {
      string       tag;
      logic [31:0] epc;
      logic [31:0] cause;
   } item_t;

   item_t       sb[$];
   logic [31:0] m_epc = '0;
   logic [31:0] m_cause = '0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit we_e, input bit we_c,
                       input bit sel, input logic [31:0] pc);
      item_t it;
      @(negedge clk);
      epc_we = we_e; cause_we = we_c; cause_sel = sel; pc_in = pc;
      if (we_e) m_epc = pc - 32'd4;
      if (we_c) m_cause = sel ? 32'h0000_0030 : 32'h0000_0028;
      it.tag = tag; it.epc = m_epc; it.cause = m_cause;
      sb.push_back(it);
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         chk(it.tag, "epc_q", epc_q, it.epc);
         chk(it.tag, "cause_q", cause_q, it.cause);
         chk("R7", "vector_addr", vector_addr, 32'h8000_0180);
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "epc_q at reset", epc_q, 32'h0);
      chk("R1", "cause_q at reset", cause_q, 32'h0);
      chk("R7", "vector_addr at reset", vector_addr, 32'h8000_0180);
      rst_n = 1'b1;

      step("R2",  1, 0, 0, 32'h0040_0004);   // capture; cause untouched
      step("R3",  0, 0, 1, 32'h1234_5678);   // neither strobe: hold
      step("R4",  0, 1, 0, 32'hDEAD_BEEC);   // illegal -> 0x28, epc held
      step("R5",  0, 1, 1, 32'h0000_1000);   // overflow -> 0x30
      step("R6",  0, 0, 0, 32'h0000_2000);   // sel toggles, cause held
      step("R9",  0, 1, 0, 32'h0000_3000);   // overflow then illegal: exactly 0x28
      step("R8",  1, 1, 1, 32'h0000_0000);   // wrap to 0xFFFFFFFC, both strobes
      step("R2",  1, 0, 0, 32'hBFC0_0008);   // high address
      step("R3",  0, 1, 1, 32'h7777_7770);   // cause only, epc held
      @(negedge clk);
      epc_we = 0; cause_we = 0;
      wait (sb.size() == 0);
      @(negedge clk);
      chk("R8", "epc_q before reset", epc_q, 32'hBFC0_0004);
      rst_n = 1'b0;
      #1;
      chk("R1", "epc_q mid-run reset", epc_q, 32'h0);
      chk("R1", "cause_q mid-run reset", cause_q, 32'h0);
      repeat (2) @(negedge clk);
      chk("R1", "epc_q held in reset", epc_q, 32'h0);
      rst_n = 1'b1;
      step("R2",  1, 1, 0, 32'h0000_0104);
      @(negedge clk);
      epc_we = 0; cause_we = 0;
      wait (sb.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule